// File: doc/BRIEF.md
# Coprocessor-0 Status, Cause and Exception Control

This block holds the processor's Status, Cause and exception-PC registers and decides, cycle by cycle, whether an exception is entered. A request can come from the pipeline directly (overflow, break, syscall and similar), and the block can also raise one itself in three cases: an instruction that targets a disabled coprocessor, a read of control register 0, or a software interrupt that a register write has just unmasked. On entry it pushes the kernel/interrupt-enable stack and records the code, the coprocessor number and the delay-slot flag in Cause. It saves the restart PC and pulses a taken flag together with a fixed vector address.

The pipeline drives the PC of the instruction currently at the commit point, a delay-slot flag and a retire strobe. It also drives control-register writes (select plus data), control-register reads (select only) and a return-from-exception strobe. Software-interrupt checks run only after writes and returns, not continuously, because hardware interrupt lines are not part of this block. A Status write that unmasks a pending request lets one more instruction retire before the trap is taken.

Top module: `cp0_ctrl`

## Requirements
- R1: After reset, status_o equals the STATUS_RST parameter (default 0), cause_o and epc_o are 0, exc_taken_o and iso_chg_o are 0, and cop_usable_o is 4'b0001.
- R2: A return strobe with no exception in that cycle makes status_o[3:0] take the old status_o[5:2] while bits 31:4 stay unchanged, visible the cycle after the strobe.
- R3: A write with select 13 changes only cause_o[9:8]; every other Cause bit keeps its value.
- R4: On exception entry, status_o[5:0] becomes {old status_o[3:0], 2'b00}, cause_o[6:2] takes the exception code, cause_o[29:28] the coprocessor number and cause_o[31] the delay-slot flag. exc_taken_o is high for exactly the cycle after the request edge, and exc_vector_o holds the VEC_ADDR parameter.
- R5: epc_o takes pc_i of the faulting instruction, or pc_i minus 4 when in_delay_i is set.
- R6: cop_op_i with cop_num_i = n (n = 1, 2 or 3) while status_o[28+n] is 0 raises exception code 10 with n in cause_o[29:28].
- R7: cop_usable_o is {status_o[31], status_o[30], status_o[29], 1'b1}, and an instruction for an enabled coprocessor raises nothing.
- R8: mfc0_i with select 0 raises exception code 10 with cause_o[29:28] = 0. Reads of other selects raise nothing.
- R9: In the cycle after a Cause write or a return strobe, if (cause & status & 0x300) is nonzero and status bit 0 is 1, a software-interrupt exception with code 0 is taken; exc_taken_o rises two cycles after the write edge.
- R10: After a Status write, the software-interrupt check waits for one instr_done_i pulse after the write and is made in the cycle after that pulse.
- R11: iso_chg_o pulses for one cycle after a Status write that changes bit 16, and stays low for a write that keeps it.
- R12: Exception sources rank: pipeline request, then coprocessor trap, then register-0 read, then software interrupt. In an exception cycle, register writes and the return strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the instruction at commit |
| in_delay_i | input | 1 | That instruction sits in a branch delay slot |
| instr_done_i | input | 1 | Instruction retired strobe |
| exc_req_i | input | 1 | Pipeline exception request |
| exc_code_i | input | 5 | Code for the pipeline request |
| exc_cop_i | input | 2 | Coprocessor number for the pipeline request |
| cop_op_i | input | 1 | Coprocessor instruction at commit |
| cop_num_i | input | 2 | Coprocessor it targets |
| mtc0_i | input | 1 | Control-register write |
| mfc0_i | input | 1 | Control-register read |
| reg_sel_i | input | 5 | Register select for read or write |
| wr_data_i | input | 32 | Write data |
| rfe_i | input | 1 | Return-from-exception strobe |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Saved exception PC |
| exc_taken_o | output | 1 | Exception entered last edge |
| exc_vector_o | output | 32 | Redirect address |
| cop_usable_o | output | 4 | Coprocessor enables |
| iso_chg_o | output | 1 | Cache-isolate bit changed |

## Verification
Register effects of a write, a return or a directly caused exception are due one cycle after the edge that sees the stimulus. A software interrupt unmasked by Cause or a return is due two cycles after the write edge. One unmasked by Status is due one cycle after the first retire pulse that follows the write. The bench drives on falling edges, keeps a behavioural model stepped on rising edges, and compares every output at each falling edge. Directed checks are sampled on exactly those due falling edges, and the cycles just before them are checked for the absence of a trap.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  localparam int XLEN      = 32;
  localparam int SEL_W     = 5;
  localparam int CODE_W    = 5;
  localparam int NUM_COP   = 4;
  localparam int COP_W     = $clog2(NUM_COP);
  localparam int CU_LSB    = 28;  // usable bit for cop n is CU_LSB + n
  localparam int ISO_BIT   = 16;

  localparam logic [SEL_W-1:0]  SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0]  SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0]  SEL_BAD    = 5'd0;

  localparam logic [CODE_W-1:0] CODE_INT   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_RSVD  = 5'd10;

  localparam logic [XLEN-1:0]   SWI_MASK   = 32'h0000_0300;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
    logic [COP_W-1:0]  cop;
  } exc_sel_t;
endpackage

// File: rtl/cp0_exc_arb.sv
module cp0_exc_arb
  import cp0_pkg::*;
(
  input  logic              ext_req_i,
  input  logic [CODE_W-1:0] ext_code_i,
  input  logic [COP_W-1:0]  ext_cop_i,
  input  logic              cop_op_i,
  input  logic [COP_W-1:0]  cop_num_i,
  input  logic [NUM_COP-1:0] cop_usable_i,
  input  logic              mfc0_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic              swi_fire_i,
  output exc_sel_t          exc_o
);
  logic cop_trap;
  logic rd_trap;

  assign cop_trap = cop_op_i && !cop_usable_i[cop_num_i];
  assign rd_trap  = mfc0_i && (reg_sel_i == SEL_BAD);

  always_comb begin
    exc_o = '0;
    if (ext_req_i) begin
      exc_o = '{valid: 1'b1, code: ext_code_i, cop: ext_cop_i};
    end else if (cop_trap) begin
      exc_o = '{valid: 1'b1, code: CODE_RSVD, cop: cop_num_i};
    end else if (rd_trap) begin
      exc_o = '{valid: 1'b1, code: CODE_RSVD, cop: '0};
    end else if (swi_fire_i) begin
      exc_o = '{valid: 1'b1, code: CODE_INT, cop: '0};
    end
  end
endmodule

// File: rtl/cp0_swi_ctrl.sv
module cp0_swi_ctrl
  import cp0_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_commit_i,
  input  logic            cause_wr_i,
  input  logic            status_wr_i,
  input  logic            rfe_i,
  input  logic            instr_done_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] cause_i,
  output logic            swi_fire_o
);
  logic chk_now_q;
  logic chk_wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_now_q  <= 1'b0;
      chk_wait_q <= 1'b0;
    end else if (exc_commit_i) begin
      chk_now_q  <= 1'b0;
      chk_wait_q <= 1'b0;
    end else begin
      chk_now_q  <= cause_wr_i || rfe_i || (chk_wait_q && instr_done_i);
      chk_wait_q <= status_wr_i || (chk_wait_q && !instr_done_i);
    end
  end

  assign swi_fire_o = chk_now_q && (|(cause_i & status_i & SWI_MASK)) && status_i[0];
endmodule

// File: rtl/cp0_regs.sv
module cp0_regs
  import cp0_pkg::*;
#(
  parameter logic [XLEN-1:0] STATUS_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  exc_sel_t        exc_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  input  logic            status_wr_i,
  input  logic            cause_wr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            rfe_i,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic            taken_o,
  output logic            iso_chg_o
);
  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] status_q, cause_q, epc_q;
  logic            taken_q, iso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      taken_q  <= 1'b0;
      iso_q    <= 1'b0;
    end else begin
      taken_q <= exc_i.valid;
      iso_q   <= 1'b0;
      if (exc_i.valid) begin
        status_q[5:0] <= {status_q[3:0], 2'b00};
        cause_q[XLEN-1]                   <= in_delay_i;
        cause_q[CU_LSB+COP_W-1:CU_LSB]    <= exc_i.cop;
        cause_q[CODE_W+1:2]               <= exc_i.code;
        epc_q <= in_delay_i ? pc_i - PC_STEP : pc_i;
      end else if (status_wr_i) begin
        status_q <= wr_data_i;
        iso_q    <= status_q[ISO_BIT] ^ wr_data_i[ISO_BIT];
      end else if (cause_wr_i) begin
        cause_q[9:8] <= wr_data_i[9:8];
      end else if (rfe_i) begin
        status_q[3:0] <= status_q[5:2];
      end
    end
  end

  assign status_o  = status_q;
  assign cause_o   = cause_q;
  assign epc_o     = epc_q;
  assign taken_o   = taken_q;
  assign iso_chg_o = iso_q;
endmodule

// File: rtl/cp0_ctrl.sv
module cp0_ctrl
  import cp0_pkg::*;
#(
  parameter logic [XLEN-1:0] STATUS_RST = '0,
  parameter logic [XLEN-1:0] VEC_ADDR   = 32'h8000_0080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_delay_i,
  input  logic              instr_done_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [COP_W-1:0]  exc_cop_i,
  input  logic              cop_op_i,
  input  logic [COP_W-1:0]  cop_num_i,
  input  logic              mtc0_i,
  input  logic              mfc0_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              rfe_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o,
  output logic              exc_taken_o,
  output logic [XLEN-1:0]   exc_vector_o,
  output logic [NUM_COP-1:0] cop_usable_o,
  output logic              iso_chg_o
);
  exc_sel_t        exc;
  logic            swi_fire;
  logic            status_wr, cause_wr;
  logic [XLEN-1:0] status, cause;
  logic [NUM_COP-1:0] usable;

  assign status_wr = mtc0_i && (reg_sel_i == SEL_STATUS);
  assign cause_wr  = mtc0_i && (reg_sel_i == SEL_CAUSE);

  // cop0 is always usable; others follow their Status enable bit
  assign usable[0] = 1'b1;
  for (genvar g = 1; g < NUM_COP; g++) begin : g_cu
    assign usable[g] = status[CU_LSB+g];
  end

  cp0_exc_arb u_arb (
    .ext_req_i   (exc_req_i),
    .ext_code_i  (exc_code_i),
    .ext_cop_i   (exc_cop_i),
    .cop_op_i    (cop_op_i),
    .cop_num_i   (cop_num_i),
    .cop_usable_i(usable),
    .mfc0_i      (mfc0_i),
    .reg_sel_i   (reg_sel_i),
    .swi_fire_i  (swi_fire),
    .exc_o       (exc)
  );

  cp0_swi_ctrl u_swi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_commit_i(exc.valid),
    .cause_wr_i  (cause_wr),
    .status_wr_i (status_wr),
    .rfe_i       (rfe_i),
    .instr_done_i(instr_done_i),
    .status_i    (status),
    .cause_i     (cause),
    .swi_fire_o  (swi_fire)
  );

  cp0_regs #(.STATUS_RST(STATUS_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (exc),
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .status_wr_i(status_wr),
    .cause_wr_i (cause_wr),
    .wr_data_i  (wr_data_i),
    .rfe_i      (rfe_i),
    .status_o   (status),
    .cause_o    (cause),
    .epc_o      (epc_o),
    .taken_o    (exc_taken_o),
    .iso_chg_o  (iso_chg_o)
  );

  assign status_o     = status;
  assign cause_o      = cause;
  assign cop_usable_o = usable;
  assign exc_vector_o = VEC_ADDR;
endmodule

// File: rtl/cp0_ctrl_chk.sv
module cp0_ctrl_chk
  import cp0_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [XLEN-1:0]   pc_i,
  input logic              in_delay_i,
  input logic              exc_req_i,
  input logic              mtc0_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic              rfe_i,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   cause_o,
  input logic [XLEN-1:0]   epc_o,
  input logic              exc_taken_o,
  input logic              iso_chg_o
);
  AST_RFE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !mtc0_i) |=> (exc_taken_o ||
      (status_o[3:0] == $past(status_o[5:2]) && status_o[XLEN-1:4] == $past(status_o[XLEN-1:4])))); // R2

  AST_CAUSE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mtc0_i && reg_sel_i == SEL_CAUSE) |=> (exc_taken_o ||
      (cause_o[XLEN-1:10] == $past(cause_o[XLEN-1:10]) && cause_o[7:0] == $past(cause_o[7:0])))); // R3

  AST_ENTRY_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_taken_o |-> status_o[1:0] == 2'b00); // R4

  AST_EPC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && in_delay_i) |=> (epc_o == $past(pc_i) - 32'd4 && cause_o[XLEN-1])); // R5

  AST_ISO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_chg_o |-> status_o[ISO_BIT] != $past(status_o[ISO_BIT])); // R11

  AST_REQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> exc_taken_o); // R12
endmodule

bind cp0_ctrl cp0_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_i),
  .in_delay_i (in_delay_i),
  .exc_req_i  (exc_req_i),
  .mtc0_i     (mtc0_i),
  .reg_sel_i  (reg_sel_i),
  .rfe_i      (rfe_i),
  .status_o   (status_o),
  .cause_o    (cause_o),
  .epc_o      (epc_o),
  .exc_taken_o(exc_taken_o),
  .iso_chg_o  (iso_chg_o)
);

// File: tb/cp0_ctrl_tb_top.sv
module cp0_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        in_delay = 0, instr_done = 0, exc_req = 0;
  logic [4:0]  exc_code = '0;
  logic [1:0]  exc_cop = '0;
  logic        cop_op = 0;
  logic [1:0]  cop_num = '0;
  logic        mtc0 = 0, mfc0 = 0, rfe = 0;
  logic [4:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] status, cause, epc, vec;
  logic        taken, iso;
  logic [3:0]  cu;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cp0_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .in_delay_i(in_delay),
    .instr_done_i(instr_done), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .exc_cop_i(exc_cop), .cop_op_i(cop_op), .cop_num_i(cop_num),
    .mtc0_i(mtc0), .mfc0_i(mfc0), .reg_sel_i(sel), .wr_data_i(wdata),
    .rfe_i(rfe), .status_o(status), .cause_o(cause), .epc_o(epc),
    .exc_taken_o(taken), .exc_vector_o(vec), .cop_usable_o(cu), .iso_chg_o(iso)
  );

  // behavioural reference
  int unsigned m_st = 0, m_ca = 0, m_epc = 0;
  bit m_tk = 0, m_iso = 0, m_now = 0, m_wait = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ca = 0; m_epc = 0; m_tk = 0; m_iso = 0; m_now = 0; m_wait = 0;
    end else begin
      bit fire, hit;
      int unsigned code, cp;
      fire = m_now && ((m_ca & m_st & 32'h300) != 0) && m_st[0];
      hit = 1; code = 0; cp = 0;
      if (exc_req) begin code = exc_code; cp = exc_cop; end
      else if (cop_op && cop_num != 0 && !m_st[28 + cop_num]) begin code = 10; cp = cop_num; end
      else if (mfc0 && sel == 0) begin code = 10; cp = 0; end
      else if (fire) begin code = 0; cp = 0; end
      else hit = 0;
      m_tk = hit; m_iso = 0;
      if (hit) begin
        m_st = (m_st & ~32'h3F) | ((m_st << 2) & 32'h3C);
        m_ca = (m_ca & 32'h4FFF_FF83) | (in_delay << 31) | (cp << 28) | (code << 2);
        m_epc = in_delay ? pc - 4 : pc;
        m_now = 0; m_wait = 0;
      end else begin
        bit sw, cw;
        sw = mtc0 && sel == 12; cw = mtc0 && sel == 13;
        if (sw) begin m_iso = m_st[16] != wdata[16]; m_st = wdata; end
        else if (cw) m_ca = (m_ca & ~32'h300) | (wdata & 32'h300);
        else if (rfe) m_st = (m_st & ~32'hF) | ((m_st >> 2) & 32'hF);
        m_now = cw || rfe || (m_wait && instr_done);
        m_wait = sw || (m_wait && !instr_done);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, status, m_st, "model status");
    chk(cur_req, cause, m_ca, "model cause");
    chk(cur_req, epc, m_epc, "model epc");
    chk(cur_req, {31'd0, taken}, {31'd0, m_tk}, "model taken");
    chk(cur_req, {31'd0, iso}, {31'd0, m_iso}, "model iso");
    chk(cur_req, {28'd0, cu}, {28'd0, m_st[31:29], 1'b1}, "model usable");
    chk("R4", vec, VEC, "vector");
  end

  task automatic idle(); @(negedge clk); endtask
  task automatic clr();
    exc_req = 0; cop_op = 0; mtc0 = 0; mfc0 = 0; rfe = 0; instr_done = 0; in_delay = 0;
  endtask
  task automatic wr(logic [4:0] s, logic [31:0] d);
    mtc0 = 1; sel = s; wdata = d; @(negedge clk); clr();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", status, 32'h0, "reset status");
    chk("R1", cause, 32'h0, "reset cause");
    chk("R1", {28'd0, cu}, 32'h1, "reset usable");
    chk("R1", {31'd0, taken}, 32'h0, "reset taken");
    rst_n = 1;
    idle();

    cur_req = "R2";
    wr(5'd12, 32'h0000_002C);
    rfe = 1; idle(); clr();
    chk("R2", status, 32'h0000_002B, "rfe pop");

    cur_req = "R3";
    wr(5'd13, 32'hFFFF_FFFF);
    chk("R3", cause, 32'h0000_0300, "cause mask");
    idle();
    chk("R9", {31'd0, taken}, 32'h0, "masked swi not taken");

    cur_req = "R4";
    pc = 32'h1000; exc_req = 1; exc_code = 5'd12; idle(); clr();
    chk("R4", {31'd0, taken}, 32'h1, "taken pulse");
    chk("R4", cause, 32'h0000_0330, "cause code");
    chk("R4", status, 32'h0000_002C, "stack push");
    chk("R5", epc, 32'h1000, "epc plain");
    idle();
    chk("R4", {31'd0, taken}, 32'h0, "pulse one cycle");

    cur_req = "R5";
    pc = 32'h2000; in_delay = 1; exc_req = 1; exc_code = 5'd9; idle(); clr();
    chk("R5", epc, 32'h0000_1FFC, "epc delay slot");
    chk("R5", cause, 32'h8000_0324, "delay flag");
    chk("R4", status, 32'h0000_0030, "second push");

    cur_req = "R6";
    pc = 32'h3000; cop_op = 1; cop_num = 2; idle(); clr();
    chk("R6", cause, 32'h2000_0328, "cop unusable");
    chk("R6", epc, 32'h3000, "cop epc");

    cur_req = "R7";
    wr(5'd12, 32'h4000_0000);
    chk("R7", {28'd0, cu}, 32'h5, "usable bits");
    cop_op = 1; cop_num = 2; pc = 32'h3100; idle(); clr();
    chk("R7", {31'd0, taken}, 32'h0, "enabled cop no trap");
    chk("R7", epc, 32'h3000, "epc kept");

    cur_req = "R8";
    pc = 32'h4000; mfc0 = 1; sel = 5'd12; idle(); clr();
    chk("R8", {31'd0, taken}, 32'h0, "read sel 12 ok");
    mfc0 = 1; sel = 5'd0; idle(); clr();
    chk("R8", cause, 32'h0000_0328, "read sel 0 trap");
    chk("R8", {31'd0, taken}, 32'h1, "read sel 0 taken");

    cur_req = "R9";
    wr(5'd12, 32'h0000_0301);
    pc = 32'h5000;
    wr(5'd13, 32'h0000_0100);
    chk("R9", {31'd0, taken}, 32'h0, "not yet after write edge");
    idle();
    chk("R9", {31'd0, taken}, 32'h1, "swi taken");
    chk("R9", cause, 32'h0000_0100, "swi code 0");
    chk("R9", status, 32'h0000_0304, "swi push");
    chk("R9", epc, 32'h5000, "swi epc");

    cur_req = "R10";
    pc = 32'h6000;
    wr(5'd12, 32'h0000_0101);
    chk("R10", {31'd0, taken}, 32'h0, "no swi at write");
    idle(); idle();
    chk("R10", {31'd0, taken}, 32'h0, "waits for retire");
    instr_done = 1; idle(); clr();
    chk("R10", {31'd0, taken}, 32'h0, "retire edge");
    idle();
    chk("R10", {31'd0, taken}, 32'h1, "taken after retire");
    chk("R10", status, 32'h0000_0104, "status push");

    cur_req = "R11";
    wr(5'd12, 32'h0001_0104);
    chk("R11", {31'd0, iso}, 32'h1, "isolate change");
    wr(5'd12, 32'h0001_0104);
    chk("R11", {31'd0, iso}, 32'h0, "isolate same");

    cur_req = "R12";
    pc = 32'h7000; exc_req = 1; exc_code = 5'd12; exc_cop = 2'd0;
    cop_op = 1; cop_num = 3; mtc0 = 1; sel = 5'd12; wdata = 32'h0000_FFFF;
    idle(); clr();
    chk("R12", cause, 32'h0000_0130, "request wins");
    chk("R12", status, 32'h0001_0110, "write ignored");
    chk("R12", {31'd0, iso}, 32'h0, "no isolate pulse");
    idle(); idle();

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule